// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches a small number of page translations and turns a 32-bit virtual address into a 24-bit physical address. Pages are 256 bytes. The low 8 address bits are the offset within the page and pass through unchanged. The upper 24 bits form the virtual page number, and each cached entry maps one virtual page number to a 16-bit physical page number. The lookup compares the virtual page number against every entry in parallel. The result is captured in a register, so it appears one clock after the request.

When no valid entry matches, the block reports a miss and takes no other action. An outside handler finds the translation and writes it in through the refill port. The block chooses which slot to overwrite by itself. It first takes a slot that holds nothing. If every slot is valid, it takes the first slot that has not been touched since the usage bits were last cleared. If every usage bit is set, it clears them all and takes slot 0.

Each entry tracks whether a write has hit it. On every refill the block reports the page numbers and the modified flag of the entry it pushed out, so the handler can write that state back into the page table. A flush input invalidates every entry at once.

Top module: `tlb_fa`

## Requirements
- R1: Out of reset and after every flush, no entry is valid. Every lookup misses, and `lk_hit` and `lk_rsp_valid` are 0 until a request is made.
- R2: A lookup presented at clock edge k produces, right after edge k+1, `lk_rsp_valid`=1. On a hit it also produces `lk_paddr` = {physical page number of the matching entry, `lk_vaddr[7:0]`}. `lk_rsp_valid` is 0 after any edge without a request.
- R3: A lookup whose `lk_vaddr[31:8]` matches no valid entry responds with `lk_hit`=0 and `lk_paddr`=0.
- R4: A refill writes the lowest-indexed invalid entry when one exists. In that case `ev_valid` is 0 in the following cycle.
- R5: When all entries are valid and at least one usage bit is 0, a refill replaces the lowest-indexed entry whose usage bit is 0. In the following cycle it raises `ev_valid` for one cycle, with `ev_vpn` and `ev_ppn` set to the replaced entry's old page numbers.
- R6: When all entries are valid and every usage bit is 1, a refill clears every usage bit and replaces entry 0. The new entry is the only one left with its usage bit set.
- R7: A write lookup (`lk_write`=1) that hits sets that entry's modified bit, and a read hit leaves it unchanged. The bit is reported on `ev_dirty` when the entry is later evicted.
- R8: Any lookup hit, read or write, sets the matching entry's usage bit.
- R9: `flush` takes priority over a refill in the same cycle. Its effect is visible from the next request onward.
- R10: A newly refilled entry starts with its modified bit 0 and its usage bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_req | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_rsp_valid | output | 1 | Registered response strobe |
| lk_hit | output | 1 | Registered hit flag |
| lk_paddr | output | 24 | Registered physical address |
| rf_valid | input | 1 | Refill strobe |
| rf_vpn | input | 24 | Virtual page number to install |
| rf_ppn | input | 16 | Physical page number to install |
| ev_valid | output | 1 | A valid entry was displaced by the last refill |
| ev_dirty | output | 1 | Modified flag of the displaced entry |
| ev_vpn | output | 24 | Virtual page number of the displaced entry |
| ev_ppn | output | 16 | Physical page number of the displaced entry |

## Verification
The assertions check every cycle that the response strobe follows the request by exactly one clock, and that a hit carries the request's page offset. They also check that a hit never appears without a response, that the eviction report fires only after a refill, and that a flush leaves no valid entry and no hit on the next request. The choice of victim, the sweep of usage bits, and the modified flag carried to the eviction report depend on the access history. Only the bench's scenarios can show those: a reference model predicts each victim's page numbers and dirty flag, and the bench compares them with the report.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   // How the replacement slot was chosen
   typedef enum logic [1:0] {
      PICK_FREE  = 2'd0,   // an invalid slot
      PICK_COLD  = 2'd1,   // a valid slot with usage bit clear
      PICK_SWEEP = 2'd2    // all usage bits set: clear them, take slot 0
   } pick_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
   parameter int N     = 8,
   parameter int TAG_W = 24,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]            vld,
   input  logic [N-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]        key,
   output logic [N-1:0]            onehot,
   output logic                    hit,
   output logic [IDX_W-1:0]        idx
);
   logic [N-1:0] raw;

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_cmp
         assign raw[g] = vld[g] && (tags[g] == key);
      end
   endgenerate

   // lowest index wins if a key is cached twice
   always_comb begin
      idx    = '0;
      onehot = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (raw[i]) idx = IDX_W'(i);
      end
      if (|raw) onehot[idx] = 1'b1;
   end

   assign hit = |raw;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
   import tlb_pkg::*;
#(
   parameter int N = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     vld,
   input  logic [N-1:0]     used,
   output logic [IDX_W-1:0] idx,
   output pick_e            pick
);
   logic [IDX_W-1:0] free_idx, cold_idx;

   always_comb begin
      free_idx = '0;
      cold_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!vld[i])  free_idx = IDX_W'(i);
         if (!used[i]) cold_idx = IDX_W'(i);
      end
   end

   always_comb begin
      if (!(&vld)) begin
         pick = PICK_FREE;
         idx  = free_idx;
      end else if (!(&used)) begin
         pick = PICK_COLD;
         idx  = cold_idx;
      end else begin
         pick = PICK_SWEEP;
         idx  = '0;
      end
   end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
   import tlb_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int PA_W    = 24,
   parameter int OFS_W   = 8,
   parameter int ENTRIES = 8,
   localparam int VPN_W  = VA_W - OFS_W,
   localparam int PPN_W  = PA_W - OFS_W,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             lk_req,
   input  logic             lk_write,
   input  logic [VA_W-1:0]  lk_vaddr,
   output logic             lk_rsp_valid,
   output logic             lk_hit,
   output logic [PA_W-1:0]  lk_paddr,
   input  logic             rf_valid,
   input  logic [VPN_W-1:0] rf_vpn,
   input  logic [PPN_W-1:0] rf_ppn,
   output logic             ev_valid,
   output logic             ev_dirty,
   output logic [VPN_W-1:0] ev_vpn,
   output logic [PPN_W-1:0] ev_ppn
);
   generate
      if (ENTRIES < 2)       begin : g_bad_n   $error("ENTRIES must be at least 2"); end
      if (OFS_W >= VA_W)     begin : g_bad_va  $error("offset must be narrower than VA"); end
      if (OFS_W >= PA_W)     begin : g_bad_pa  $error("offset must be narrower than PA"); end
   endgenerate

   // entry storage
   logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
   logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
   logic [ENTRIES-1:0]            vld_q, dirty_q, used_q;
   logic [ENTRIES-1:0]            vld_d, dirty_d, used_d;

   logic [ENTRIES-1:0] m_onehot;
   logic               m_hit;
   logic [IDX_W-1:0]   m_idx;
   logic [IDX_W-1:0]   v_idx;
   pick_e              v_pick;
   logic               do_rf;

   tlb_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_match (
      .vld   (vld_q),
      .tags  (tag_q),
      .key   (lk_vaddr[VA_W-1:OFS_W]),
      .onehot(m_onehot),
      .hit   (m_hit),
      .idx   (m_idx)
   );

   tlb_victim #(.N(ENTRIES)) u_victim (
      .vld (vld_q),
      .used(used_q),
      .idx (v_idx),
      .pick(v_pick)
   );

   assign do_rf = rf_valid && !flush;

   // next-state of per-entry flags
   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         vld_d[i]   = vld_q[i];
         used_d[i]  = used_q[i];
         dirty_d[i] = dirty_q[i];
         if (do_rf && v_pick == PICK_SWEEP) used_d[i] = 1'b0;
         if (lk_req && m_onehot[i]) begin
            used_d[i] = 1'b1;
            if (lk_write) dirty_d[i] = 1'b1;
         end
         if (do_rf && v_idx == IDX_W'(i)) begin
            vld_d[i]   = 1'b1;
            used_d[i]  = 1'b1;
            dirty_d[i] = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q        <= '0;
         dirty_q      <= '0;
         used_q       <= '0;
         tag_q        <= '0;
         ppn_q        <= '0;
         lk_rsp_valid <= 1'b0;
         lk_hit       <= 1'b0;
         lk_paddr     <= '0;
         ev_valid     <= 1'b0;
         ev_dirty     <= 1'b0;
         ev_vpn       <= '0;
         ev_ppn       <= '0;
      end else begin
         lk_rsp_valid <= lk_req;
         lk_hit       <= lk_req && m_hit;
         lk_paddr     <= (lk_req && m_hit) ?
                         {ppn_q[m_idx], lk_vaddr[OFS_W-1:0]} : '0;
         ev_valid     <= do_rf && (v_pick != PICK_FREE);
         if (do_rf) begin
            ev_dirty     <= (v_pick != PICK_FREE) && dirty_q[v_idx];
            ev_vpn       <= (v_pick != PICK_FREE) ? tag_q[v_idx] : '0;
            ev_ppn       <= (v_pick != PICK_FREE) ? ppn_q[v_idx] : '0;
            tag_q[v_idx] <= rf_vpn;
            ppn_q[v_idx] <= rf_ppn;
         end
         if (flush) begin
            vld_q   <= '0;
            dirty_q <= '0;
            used_q  <= '0;
         end else begin
            vld_q   <= vld_d;
            dirty_q <= dirty_d;
            used_q  <= used_d;
         end
      end
   end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
   parameter int VA_W    = 32,
   parameter int PA_W    = 24,
   parameter int OFS_W   = 8,
   parameter int ENTRIES = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               flush,
   input logic               lk_req,
   input logic [VA_W-1:0]    lk_vaddr,
   input logic               rf_valid,
   input logic               lk_rsp_valid,
   input logic               lk_hit,
   input logic [PA_W-1:0]    lk_paddr,
   input logic               ev_valid,
   input logic [ENTRIES-1:0] vld_q
);
   // R2
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> lk_rsp_valid);
   // R2
   no_rsp_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> !lk_rsp_valid);
   // R2
   offset_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> (!lk_hit || lk_paddr[OFS_W-1:0] == $past(lk_vaddr[OFS_W-1:0])));
   // R3
   hit_implies_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_rsp_valid);
   // R5
   evict_only_after_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rf_valid |=> !ev_valid);
   // R9
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> vld_q == '0);
   // R9
   flush_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (lk_req |=> !lk_hit));
   // R1
   reset_empty_chk: assert property (@(posedge clk)
      !rst_n |=> (vld_q == '0 && !lk_rsp_valid && !ev_valid));
endmodule

bind tlb_fa tlb_fa_chk #(
   .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .ENTRIES(ENTRIES)
) u_tlb_fa_chk (
   .clk(clk), .rst_n(rst_n), .flush(flush), .lk_req(lk_req),
   .lk_vaddr(lk_vaddr), .rf_valid(rf_valid), .lk_rsp_valid(lk_rsp_valid),
   .lk_hit(lk_hit), .lk_paddr(lk_paddr), .ev_valid(ev_valid), .vld_q(vld_q)
);

// File: tb/test_tlb_fa.sv
`timescale 1ns/100ps
module test_tlb_fa;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        lk_req = 1'b0;
   logic        lk_write = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic        lk_rsp_valid, lk_hit;
   logic [23:0] lk_paddr;
   logic        rf_valid = 1'b0;
   logic [23:0] rf_vpn = '0;
   logic [15:0] rf_ppn = '0;
   logic        ev_valid, ev_dirty;
   logic [23:0] ev_vpn;
   logic [15:0] ev_ppn;

   int checks = 0;
   int errors = 0;

   // reference model
   logic        m_vld   [N];
   logic        m_dirty [N];
   logic        m_used  [N];
   logic [23:0] m_tag   [N];
   logic [15:0] m_ppn   [N];

   always #2.5 clk = ~clk;

   tlb_fa i_tlb_fa (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_req(lk_req), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
      .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
      .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
      .ev_valid(ev_valid), .ev_dirty(ev_dirty), .ev_vpn(ev_vpn), .ev_ppn(ev_ppn)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] pool_vpn(input int p);
      return 24'h3C0000 + 24'(p) * 24'h000111;
   endfunction

   function automatic int model_find(input logic [23:0] vpn);
      for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == vpn) return i;
      return -1;
   endfunction

   task automatic model_clear();
      for (int i = 0; i < N; i++) begin
         m_vld[i] = 0; m_dirty[i] = 0; m_used[i] = 0; m_tag[i] = '0; m_ppn[i] = '0;
      end
   endtask

   task automatic do_lookup(input logic [31:0] va, input logic wr);
      int k;
      logic [23:0] exp_pa;
      k = model_find(va[31:8]);
      exp_pa = (k >= 0) ? {m_ppn[k], va[7:0]} : 24'h0;
      @(negedge clk);
      lk_req = 1'b1; lk_write = wr; lk_vaddr = va;
      @(posedge clk); #1;
      lk_req = 1'b0; lk_write = 1'b0;
      check("R2 rsp_valid", 32'(lk_rsp_valid), 32'd1);
      check((k >= 0) ? "R2 hit" : "R3 miss", 32'(lk_hit), 32'(k >= 0));
      check((k >= 0) ? "R2 paddr" : "R3 paddr", 32'(lk_paddr), 32'(exp_pa));
      if (k >= 0) begin
         m_used[k] = 1;             // R8
         if (wr) m_dirty[k] = 1;    // R7
      end
   endtask

   task automatic do_refill(input logic [23:0] vpn, input logic [15:0] ppn);
      int v = -1;
      logic sweep = 0;
      logic exp_ev;
      for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) v = i;
      if (v < 0) for (int i = N - 1; i >= 0; i--) if (!m_used[i]) v = i;
      if (v < 0) begin v = 0; sweep = 1; end
      exp_ev = m_vld[v];
      @(negedge clk);
      rf_valid = 1'b1; rf_vpn = vpn; rf_ppn = ppn;
      @(posedge clk); #1;
      rf_valid = 1'b0;
      check(exp_ev ? "R5 ev_valid" : "R4 ev_valid", 32'(ev_valid), 32'(exp_ev));
      if (exp_ev) begin
         check(sweep ? "R6 ev_vpn" : "R5 ev_vpn", 32'(ev_vpn), 32'(m_tag[v]));
         check(sweep ? "R6 ev_ppn" : "R5 ev_ppn", 32'(ev_ppn), 32'(m_ppn[v]));
         check("R7 ev_dirty", 32'(ev_dirty), 32'(m_dirty[v]));
      end
      if (sweep) for (int i = 0; i < N; i++) m_used[i] = 0;
      m_vld[v] = 1; m_dirty[v] = 0; m_used[v] = 1; m_tag[v] = vpn; m_ppn[v] = ppn;
   endtask

   task automatic do_flush(input logic with_refill);
      @(negedge clk);
      flush = 1'b1;
      rf_valid = with_refill; rf_vpn = pool_vpn(15); rf_ppn = 16'hDEAD;
      @(posedge clk); #1;
      flush = 1'b0; rf_valid = 1'b0;
      model_clear();   // R9: flush wins over refill
   endtask

   initial begin : watchdog
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd4242));
      model_clear();
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1 rsp_valid", 32'(lk_rsp_valid), 32'd0);
      check("R1 hit", 32'(lk_hit), 32'd0);
      @(negedge clk); rst_n = 1'b1;
      do_lookup({pool_vpn(0), 8'h12}, 1'b0);          // R1 miss when empty

      // R4: fill all slots in order
      for (int i = 0; i < N; i++) do_refill(pool_vpn(i), 16'h1000 + 16'(i));
      // R2: hits with varied offsets, R7 write on slot 3
      for (int i = 0; i < N; i++) do_lookup({pool_vpn(i), 8'(i * 37)}, 1'b0);
      do_lookup({pool_vpn(3), 8'hFF}, 1'b1);
      // R6: all usage set -> sweep replaces slot 0
      do_refill(pool_vpn(8), 16'h2008);
      // R5: next victim is slot 1 (usage clear)
      do_refill(pool_vpn(9), 16'h2009);
      // R8: touch slot 2 so slot 3 (dirty) goes next, R7 dirty report
      do_lookup({pool_vpn(2), 8'h00}, 1'b0);
      do_refill(pool_vpn(10), 16'h200A);
      // R10: fresh entry clean; R7: read hit leaves clean
      do_lookup({pool_vpn(10), 8'h44}, 1'b0);
      // R9: flush with a concurrent refill, then lookups miss and refill goes to slot 0
      do_flush(1'b1);
      do_lookup({pool_vpn(15), 8'h01}, 1'b0);
      do_lookup({pool_vpn(8), 8'h02}, 1'b0);
      do_refill(pool_vpn(4), 16'h3004);
      do_lookup({pool_vpn(4), 8'hA5}, 1'b1);

      // constrained random mix
      for (int n = 0; n < 1500; n++) begin
         int r = int'($urandom_range(0, 99));
         if (r < 55) begin
            logic [31:0] va;
            if ($urandom_range(0, 9) < 8) va = {pool_vpn(int'($urandom_range(0, 15))), 8'($urandom())};
            else va = $urandom();
            do_lookup(va, 1'($urandom_range(0, 1)));
         end else if (r < 97) begin
            int p;
            do p = int'($urandom_range(0, 15)); while (model_find(pool_vpn(p)) >= 0);
            do_refill(pool_vpn(p), 16'($urandom()));
         end else begin
            do_flush(1'($urandom_range(0, 1)));
         end
      end

      @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule